// File: doc/BRIEF.md
# Four-Lane Multiply-Add Neuron with Rectified Output

This block is a pipelined neuron cell for convolution layers. Every clock cycle it can take in one operand set: four signed feature values and four signed weights. It multiplies the four pairs at the same time, adds the four products in a single addition stage, and adds that sum into a running accumulator. A rectified-linear stage then clamps any negative accumulated value to zero.

A valid strobe travels alongside the data. The output strobe rises exactly four cycles after an accepted set. Back-to-back sets are accepted without bubbles, so a full pipeline fires one result per clock.

A clear strobe starts a new dot product. If it arrives together with a valid set, that set is the first term of the new sum. If it arrives without one, the accumulator is zeroed and nothing is output.

Top module: `relu_neuron`

## Requirements
- R1: During reset and on the first cycle after it, `valid_out` is 0 and `relu_out` is 0, and the accumulator starts from zero.
- R2: Lane i takes its feature value from `feat_in[i*8 +: 8]` and its weight from `wgt_in[i*9 +: 9]`, both two's complement. Each set contributes the exact signed sum of the four lane products.
- R3: `valid_out` is high exactly four clock edges after the edge that samples `valid_in` high, and it is low otherwise.
- R4: Consecutive valid sets with `clear_in` low add into the same accumulator, with one output per set and no gap cycles required.
- R5: A valid set presented with `clear_in` high produces an output equal to that set's own dot product. Earlier sets are discarded.
- R6: `relu_out` is 0 whenever the signed accumulator value is negative, and equals it otherwise. Its most significant bit is always 0.
- R7: Cycles with `valid_in` low do not change the accumulator, whatever is on the data inputs. While `valid_out` is low, `relu_out` holds its last value.
- R8: `clear_in` high with `valid_in` low zeroes the accumulator without raising `valid_out`. The next valid set then starts from zero.
- R9: Extreme operands (-128 by -256, 127 by -256, -128 by 255) give exact results, and sums of several such sets accumulate without wrap inside the 24-bit range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Operand set on the data inputs is valid |
| clear_in | input | 1 | Restart the accumulation |
| feat_in | input | 32 | Four packed signed 8-bit feature values, lane 0 in the low bits |
| wgt_in | input | 36 | Four packed signed 9-bit weights, lane 0 in the low bits |
| valid_out | output | 1 | `relu_out` carries a fresh result |
| relu_out | output | 24 | Rectified accumulator value |

## Verification
The bench builds the block with its default parameters: four lanes, 8-bit features, 9-bit weights and a 24-bit accumulator. At these widths every feature value can be swept against the boundary weights in each lane position. The other three lanes carry a large positive bias, so negative products still show through the rectifier. Long unbroken accumulation runs, idle gaps carrying garbage data, clears with and without a valid set, and extreme-magnitude sets cover the accumulator's control and range.

// File: rtl/relu_neuron.sv
module relu_neuron #(
  parameter int LANES = 4,
  parameter int XW    = 8,
  parameter int WW    = 9,
  parameter int ACCW  = 24
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  valid_in,
  input  logic                  clear_in,
  input  logic [LANES*XW-1:0]   feat_in,
  input  logic [LANES*WW-1:0]   wgt_in,
  output logic                  valid_out,
  output logic [ACCW-1:0]       relu_out
);
  localparam int PW = XW + WW;
  localparam int SW = PW + $clog2(LANES);

  // control tokens: [0] operand regs, [1] products, [2] sum
  logic [2:0] vld_q, clr_q;

  logic signed [XW-1:0]   x_q [LANES];
  logic signed [WW-1:0]   w_q [LANES];
  logic signed [PW-1:0]   p_q [LANES];
  logic signed [SW-1:0]   sum_c, sum_q;
  logic signed [ACCW-1:0] acc_q, acc_base, acc_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      clr_q <= '0;
    end else begin
      vld_q <= {vld_q[1:0], valid_in};
      clr_q <= {clr_q[1:0], clear_in};
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        x_q[i] <= '0;
        w_q[i] <= '0;
        p_q[i] <= '0;
      end else begin
        x_q[i] <= feat_in[i*XW +: XW];
        w_q[i] <= wgt_in[i*WW +: WW];
        p_q[i] <= PW'(x_q[i]) * PW'(w_q[i]);
      end
    end
  end

  always_comb begin
    sum_c = '0;
    for (int i = 0; i < LANES; i++) sum_c += SW'(p_q[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_c;
  end

  assign acc_base = clr_q[2] ? '0 : acc_q;
  assign acc_nxt  = acc_base + ACCW'(sum_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      relu_out  <= '0;
      valid_out <= 1'b0;
    end else begin
      valid_out <= vld_q[2];
      if (vld_q[2]) begin
        acc_q    <= acc_nxt;
        relu_out <= acc_nxt[ACCW-1] ? '0 : $unsigned(acc_nxt);
      end else if (clr_q[2]) begin
        acc_q <= '0;
      end
    end
  end
endmodule

// File: rtl/relu_neuron_chk.sv
module relu_neuron_chk #(
  parameter int ACCW = 24
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   valid_in,
  input logic                   valid_out,
  input logic [ACCW-1:0]        relu_out,
  input logic signed [ACCW-1:0] acc_q
);
  logic [3:0] vin_hist;

  always_ff @(posedge clk) begin
    if (!rst_n) vin_hist <= '0;
    else        vin_hist <= {vin_hist[2:0], valid_in};
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!valid_out && relu_out == '0)); // R1

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out == vin_hist[3]); // R3

  AST_RELU_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    relu_out[ACCW-1] == 1'b0); // R6

  AST_OUT_TRACKS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> relu_out == (acc_q[ACCW-1] ? '0 : $unsigned(acc_q))); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_out |-> $stable(relu_out)); // R7
endmodule

bind relu_neuron relu_neuron_chk #(.ACCW(ACCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_in(valid_in),
  .valid_out(valid_out), .relu_out(relu_out), .acc_q(acc_q)
);

// File: tb/relu_neuron_bench.sv
module relu_neuron_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_in = 1'b0;
  logic        clear_in = 1'b0;
  logic [31:0] feat_in = '0;
  logic [35:0] wgt_in = '0;
  logic        valid_out;
  logic [23:0] relu_out;

  always #2.5 clk = ~clk;

  relu_neuron u_relu_neuron (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .clear_in(clear_in),
    .feat_in(feat_in), .wgt_in(wgt_in),
    .valid_out(valid_out), .relu_out(relu_out)
  );

  int tests = 0;
  int fails = 0;
  int m_acc = 0;
  int m_out = 0;
  bit    hv [4];
  int    hd [4];
  string ht [4];
  int unsigned seed = 32'h1234_5678;

  function automatic int wrap24(input int v);
    int t;
    t = v & 32'h00FF_FFFF;
    if (t >= 32'h0080_0000) t = t - 32'h0100_0000;
    return t;
  endfunction

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed >> 8);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input bit c, input int xa [4], input int wa [4], input string tag);
    int dot;
    @(negedge clk);
    check(valid_out == hv[3], {ht[3], " valid_out"}, int'(valid_out), int'(hv[3]));
    check(relu_out == hd[3][23:0], {ht[3], " relu_out"}, int'(relu_out), hd[3]);
    dot = 0;
    for (int i = 0; i < 4; i++) dot += xa[i] * wa[i];
    if (v) begin
      m_acc = wrap24((c ? 0 : m_acc) + dot);
      m_out = (m_acc < 0) ? 0 : m_acc;
    end else if (c) begin
      m_acc = 0;
    end
    for (int k = 3; k > 0; k--) begin
      hv[k] = hv[k-1]; hd[k] = hd[k-1]; ht[k] = ht[k-1];
    end
    hv[0] = v; hd[0] = m_out; ht[0] = tag;
    valid_in = v;
    clear_in = c;
    for (int i = 0; i < 4; i++) begin
      feat_in[i*8 +: 8] = xa[i][7:0];
      wgt_in[i*9 +: 9]  = wa[i][8:0];
    end
  endtask

  task automatic idle(input int n, input string tag);
    int z [4];
    for (int i = 0; i < 4; i++) z[i] = 0;
    for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, z, z, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int xa [4];
    int wa [4];
    int wlist [7];
    int first_k;
    for (int k = 0; k < 4; k++) begin hv[k] = 1'b0; hd[k] = 0; ht[k] = "R1"; end
    wlist[0] = -256; wlist[1] = -255; wlist[2] = -1; wlist[3] = 0;
    wlist[4] = 1;    wlist[5] = 127;  wlist[6] = 255;

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(valid_out == 1'b0, "R1 reset valid_out", int'(valid_out), 0);
    check(relu_out == 24'd0, "R1 reset relu_out", int'(relu_out), 0);
    rst_n = 1'b1;
    idle(2, "R1");

    // R3: single set, count cycles to valid_out
    for (int i = 0; i < 4; i++) begin xa[i] = 3; wa[i] = 5; end
    cyc(1'b1, 1'b1, xa, wa, "R3");
    first_k = -1;
    for (int k = 1; k <= 8; k++) begin
      idle(1, "R3");
      if (valid_out && first_k < 0) first_k = k;
    end
    check(first_k == 4, "R3 latency", first_k, 4);

    // R2/R5: sweep every feature value against boundary weights on each lane
    for (int x = -128; x < 128; x++) begin
      for (int j = 0; j < 7; j++) begin
        for (int i = 0; i < 4; i++) begin xa[i] = 127; wa[i] = 255; end
        xa[(x + 128) % 4] = x;
        wa[(x + 128) % 4] = wlist[j];
        cyc(1'b1, 1'b1, xa, wa, "R2_R5");
      end
    end
    idle(4, "R5");

    // R4/R6: unbroken accumulation with mixed signs
    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < 4; i++) begin
        xa[i] = (rnd() & 255) - 128;
        wa[i] = (rnd() & 511) - 256;
      end
      cyc(1'b1, (n == 0), xa, wa, "R4_R6");
    end
    // R6: drive strongly negative, then recover
    for (int i = 0; i < 4; i++) begin xa[i] = 127; wa[i] = -256; end
    for (int n = 0; n < 6; n++) cyc(1'b1, 1'b0, xa, wa, "R6_neg");
    for (int i = 0; i < 4; i++) begin xa[i] = 100; wa[i] = 200; end
    for (int n = 0; n < 12; n++) cyc(1'b1, 1'b0, xa, wa, "R6_pos");

    // R7: idle gaps with garbage data do not disturb accumulation
    for (int n = 0; n < 60; n++) begin
      for (int i = 0; i < 4; i++) begin
        xa[i] = (rnd() & 255) - 128;
        wa[i] = (rnd() & 511) - 256;
      end
      cyc((rnd() & 3) == 0, 1'b0, xa, wa, "R7");
    end
    idle(4, "R7");

    // R8: clear without valid, then a plain valid set
    for (int i = 0; i < 4; i++) begin xa[i] = 50; wa[i] = 60; end
    cyc(1'b1, 1'b0, xa, wa, "R8_pre");
    cyc(1'b0, 1'b1, xa, wa, "R8_clear");
    for (int i = 0; i < 4; i++) begin xa[i] = i + 1; wa[i] = 10; end
    cyc(1'b1, 1'b0, xa, wa, "R8_fresh");
    idle(4, "R8");
    check(relu_out == 24'd100, "R8 fresh sum", int'(relu_out), 100);

    // R9: extreme operands
    for (int i = 0; i < 4; i++) begin xa[i] = -128; wa[i] = -256; end
    cyc(1'b1, 1'b1, xa, wa, "R9_max");
    cyc(1'b1, 1'b0, xa, wa, "R9_max2");
    cyc(1'b1, 1'b0, xa, wa, "R9_max3");
    for (int i = 0; i < 4; i++) begin xa[i] = -128; wa[i] = 255; end
    cyc(1'b1, 1'b0, xa, wa, "R9_minpos");
    for (int i = 0; i < 4; i++) begin xa[i] = 127; wa[i] = -256; end
    cyc(1'b1, 1'b1, xa, wa, "R9_neg");
    idle(4, "R9");
    check(relu_out == 24'd0, "R9 negative clamp", int'(relu_out), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule